// File: doc/BRIEF.md
# Adaptive/Escape Virtual-Channel Route Selector

This block makes the routing and output virtual-channel decisions for every input port of a wormhole router in an irregular on-chip network. Each physical output link is divided into two virtual channels: an adaptive channel (VC 0) that may follow any shortest path, and an escape channel (VC 1) that obeys up*/down* turn rules and so guarantees freedom from deadlock. A destination-indexed table, supplied at the block's ports, gives two port bitmasks for each destination. One mask lists the shortest-path ports and the other lists the up*/down* ports.

When a head flit arrives, the selector first tries a free shortest-path port on an adaptive channel. Only if none is free does it fall back to a free up*/down* port on an escape channel. A packet that arrived on an escape channel may never be moved back to an adaptive one. When several inputs want the same output virtual channel, a round-robin arbiter for that channel picks one. The winning input keeps its port and channel until its tail flit has been forwarded.

Each input runs a two-state controller. ST_IDLE waits for a head flit. The transition ST_IDLE→ST_HOLD is taken when a multi-flit head flit wins an output channel. ST_HOLD forwards body and tail flits on the held channel. The transition ST_HOLD→ST_IDLE is taken when the tail flit is forwarded. A single-flit packet is forwarded from ST_IDLE and leaves the controller in ST_IDLE.

Top module: `escroute_sel`

## Requirements
- R1: After reset all output virtual channels are free, and no input forwards while no flit is offered.
- R2: The flit kind field is 2 bits: 00 head, 01 body, 10 tail, 11 single-flit packet. A head or single flit from the local port (port 0) or from an adaptive channel is given the lowest-index port that is set in its destination's shortest-path mask and whose adaptive channel (VC 0) is free. The forward is reported in the same cycle.
- R3: If no shortest-path port has a free adaptive channel, the flit is given the lowest-index port that is set in the up*/down* mask and whose escape channel (VC 1) is free.
- R4: A flit that arrived on an escape channel (in_on_esc set, input port other than 0) is only ever given escape channels of up*/down* ports, even when a shortest-path adaptive channel is free. On port 0 the in_on_esc bit is ignored.
- R5: If no permitted output channel is free, a head flit is not forwarded, and it is evaluated again on every later cycle.
- R6: After a multi-flit head flit is granted, the body and tail flits of that input are forwarded on the same port and channel. The channel becomes free in the cycle after the tail flit is forwarded.
- R7: A single-flit packet is forwarded in one cycle and does not keep its output channel busy afterwards.
- R8: When inputs compete for one output channel, round-robin arbitration grants the first requester at or after the pointer, and the pointer then moves to the input after the one granted.
- R9: A body or tail flit offered on an input that holds no allocation is not forwarded.
- R10: An output channel held by one packet is never granted to another input until it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | NPORT | A flit is offered on each input |
| in_kind | input | 2*NPORT | Flit kind for each input (2 bits each) |
| in_dest | input | ID_W*NPORT | Destination node of each input's flit |
| in_on_esc | input | NPORT | Flit arrived on an escape channel |
| sp_table | input | NODES*NPORT | Shortest-path port mask, row per destination |
| ud_table | input | NODES*NPORT | Up*/down* port mask, row per destination |
| out_fwd | output | NPORT | The input's flit is forwarded this cycle |
| out_port | output | PW*NPORT | Output port of each forwarded flit |
| out_vc | output | NPORT | Output virtual channel (0 adaptive, 1 escape) |

## Verification
The assertions assume that each input follows wormhole framing: a head flit is followed by body flits and then exactly one tail flit, and no head flit arrives while the input holds an allocation. They also assume that the table rows stay constant while packets are in flight. The stimulus obeys this by sending every multi-flit packet as head, optional body, and tail on one input before that input sends another head. Stray body flits are offered only to idle inputs, and the table inputs are driven once and never changed.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
    typedef enum logic [1:0] {
        FL_HEAD   = 2'b00,
        FL_BODY   = 2'b01,
        FL_TAIL   = 2'b10,
        FL_SINGLE = 2'b11
    } flit_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } in_state_e;

    localparam logic VC_ADAPT = 1'b0;
    localparam logic VC_ESC   = 1'b1;
endpackage

// File: rtl/rsel_pick.sv
module rsel_pick #(
    parameter int NPORT = 5,
    parameter int NODES = 8,
    parameter int ID_W  = 3,
    parameter int PW    = 3
) (
    input  logic [ID_W-1:0]        dest,
    input  logic                   locked,
    input  logic [NODES*NPORT-1:0] sp_tbl,
    input  logic [NODES*NPORT-1:0] ud_tbl,
    input  logic [2*NPORT-1:0]     ovc_busy,
    output logic                   cand_ok,
    output logic [PW-1:0]          cand_port,
    output logic                   cand_vc
);
    logic [NPORT-1:0] sp_row, ud_row, sp_free, ud_free;
    logic             sp_hit, ud_hit;
    logic [PW-1:0]    sp_sel, ud_sel;

    always_comb begin
        sp_row = sp_tbl[int'(dest)*NPORT +: NPORT];
        ud_row = ud_tbl[int'(dest)*NPORT +: NPORT];
        for (int p = 0; p < NPORT; p++) begin
            sp_free[p] = sp_row[p] && !ovc_busy[2*p];
            ud_free[p] = ud_row[p] && !ovc_busy[2*p+1];
        end
        sp_hit = 1'b0;
        ud_hit = 1'b0;
        sp_sel = '0;
        ud_sel = '0;
        for (int p = NPORT-1; p >= 0; p--) begin
            if (sp_free[p]) begin
                sp_hit = 1'b1;
                sp_sel = PW'(p);
            end
            if (ud_free[p]) begin
                ud_hit = 1'b1;
                ud_sel = PW'(p);
            end
        end
        // adaptive class first, escape class as fallback; locked packets skip adaptive
        if (!locked && sp_hit) begin
            cand_ok   = 1'b1;
            cand_port = sp_sel;
            cand_vc   = rsel_pkg::VC_ADAPT;
        end else if (ud_hit) begin
            cand_ok   = 1'b1;
            cand_port = ud_sel;
            cand_vc   = rsel_pkg::VC_ESC;
        end else begin
            cand_ok   = 1'b0;
            cand_port = '0;
            cand_vc   = rsel_pkg::VC_ADAPT;
        end
    end
endmodule

// File: rtl/rsel_rr_arb.sv
module rsel_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr, ptr_nxt;
    logic          found;

    always_comb begin
        gnt     = '0;
        found   = 1'b0;
        ptr_nxt = ptr;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                found   = 1'b1;
                gnt[idx] = 1'b1;
                ptr_nxt = (idx == N-1) ? '0 : IW'(idx + 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nxt;
    end

    AST_GRANT_WHEN_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> ($countones(gnt) == 1)); // R8
    AST_GRANT_TO_ASKER: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & ~req) == '0)); // R8
endmodule

// File: rtl/rsel_in_ctrl.sv
module rsel_in_ctrl #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld,
    input  logic [1:0]    kind,
    input  logic          cand_ok,
    input  logic [PW-1:0] cand_port,
    input  logic          cand_vc,
    input  logic          won,
    output logic          want,
    output logic          fwd,
    output logic [PW-1:0] fwd_port,
    output logic          fwd_vc,
    output logic          alloc,
    output logic          rel,
    output logic [PW-1:0] hold_port,
    output logic          hold_vc
);
    import rsel_pkg::*;

    in_state_e     state, state_nxt;
    logic [PW-1:0] port_q;
    logic          vc_q;
    logic          is_head, is_single, is_body, is_tail;

    assign is_head   = (kind == FL_HEAD);
    assign is_single = (kind == FL_SINGLE);
    assign is_body   = (kind == FL_BODY);
    assign is_tail   = (kind == FL_TAIL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            port_q <= '0;
            vc_q   <= 1'b0;
        end else begin
            state <= state_nxt;
            if (alloc) begin
                port_q <= cand_port;
                vc_q   <= cand_vc;
            end
        end
    end

    always_comb begin
        want      = 1'b0;
        fwd       = 1'b0;
        fwd_port  = '0;
        fwd_vc    = 1'b0;
        alloc     = 1'b0;
        rel       = 1'b0;
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                want     = vld && (is_head || is_single) && cand_ok;
                fwd      = want && won;
                fwd_port = cand_port;
                fwd_vc   = cand_vc;
                alloc    = fwd && is_head;
                if (alloc) state_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                fwd      = vld && (is_body || is_tail);
                fwd_port = port_q;
                fwd_vc   = vc_q;
                rel      = fwd && is_tail;
                if (rel) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    assign hold_port = port_q;
    assign hold_vc   = vc_q;

    AST_IDLE_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && vld && (is_body || is_tail)) |-> !fwd); // R9
    AST_HOLD_SAME_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc ##1 (fwd && state == ST_HOLD)) |->
            (fwd_port == $past(cand_port) && fwd_vc == $past(cand_vc))); // R6
endmodule

// File: rtl/escroute_sel.sv
module escroute_sel #(
    parameter int NPORT = 5,
    parameter int NODES = 8,
    parameter int ID_W  = $clog2(NODES),
    parameter int PW    = $clog2(NPORT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORT-1:0]       in_valid,
    input  logic [2*NPORT-1:0]     in_kind,
    input  logic [ID_W*NPORT-1:0]  in_dest,
    input  logic [NPORT-1:0]       in_on_esc,
    input  logic [NODES*NPORT-1:0] sp_table,
    input  logic [NODES*NPORT-1:0] ud_table,
    output logic [NPORT-1:0]       out_fwd,
    output logic [PW*NPORT-1:0]    out_port,
    output logic [NPORT-1:0]       out_vc
);
    localparam int NOVC = 2 * NPORT;
    localparam int OW   = $clog2(NOVC);

    logic [NOVC-1:0]  ovc_busy;
    logic [NOVC-1:0]  ovc_set, ovc_clr;
    logic [NPORT-1:0] want, won, alloc, rel, cand_ok, cand_vc, hold_vc;
    logic [PW-1:0]    cand_port [NPORT];
    logic [PW-1:0]    hold_port [NPORT];
    logic [OW-1:0]    tgt_ov    [NPORT];
    logic [OW-1:0]    own_ov    [NPORT];
    logic [NPORT-1:0] ovc_req   [NOVC];
    logic [NPORT-1:0] ovc_gnt   [NOVC];

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        logic locked;
        logic [PW-1:0] fport;
        logic fvc, ffwd;
        assign locked = (i != 0) && in_on_esc[i];

        rsel_pick #(.NPORT(NPORT), .NODES(NODES), .ID_W(ID_W), .PW(PW)) u_pick (
            .dest      (in_dest[i*ID_W +: ID_W]),
            .locked    (locked),
            .sp_tbl    (sp_table),
            .ud_tbl    (ud_table),
            .ovc_busy  (ovc_busy),
            .cand_ok   (cand_ok[i]),
            .cand_port (cand_port[i]),
            .cand_vc   (cand_vc[i])
        );

        rsel_in_ctrl #(.PW(PW)) u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .vld       (in_valid[i]),
            .kind      (in_kind[2*i +: 2]),
            .cand_ok   (cand_ok[i]),
            .cand_port (cand_port[i]),
            .cand_vc   (cand_vc[i]),
            .won       (won[i]),
            .want      (want[i]),
            .fwd       (ffwd),
            .fwd_port  (fport),
            .fwd_vc    (fvc),
            .alloc     (alloc[i]),
            .rel       (rel[i]),
            .hold_port (hold_port[i]),
            .hold_vc   (hold_vc[i])
        );

        assign out_fwd[i]             = ffwd;
        assign out_port[i*PW +: PW]   = fport;
        assign out_vc[i]              = fvc;
        assign tgt_ov[i] = OW'(int'(cand_port[i]) * 2 + int'(cand_vc[i]));
        assign own_ov[i] = OW'(int'(hold_port[i]) * 2 + int'(hold_vc[i]));

        AST_ESC_STAYS_ESC: assert property (@(posedge clk) disable iff (!rst_n)
            (locked && in_valid[i] && ffwd) |-> (fvc == 1'b1)); // R4
        AST_GRANT_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            alloc[i] |-> !ovc_busy[tgt_ov[i]]); // R10
        AST_ALLOC_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            alloc[i] |=> ovc_busy[$past(tgt_ov[i])]); // R6
        AST_STALL_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[i] && !cand_ok[i] && in_kind[2*i +: 2] == 2'b00 && !ovc_busy[own_ov[i]])
                |-> !ffwd); // R5
    end

    always_comb begin
        for (int v = 0; v < NOVC; v++) begin
            for (int i = 0; i < NPORT; i++) begin
                ovc_req[v][i] = want[i] && (int'(tgt_ov[i]) == v);
            end
        end
    end

    for (genvar v = 0; v < NOVC; v++) begin : g_arb
        rsel_rr_arb #(.N(NPORT)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (ovc_req[v]),
            .gnt   (ovc_gnt[v])
        );
    end

    always_comb begin
        won     = '0;
        ovc_set = '0;
        ovc_clr = '0;
        for (int v = 0; v < NOVC; v++) won = won | ovc_gnt[v];
        for (int i = 0; i < NPORT; i++) begin
            if (alloc[i]) ovc_set[tgt_ov[i]] = 1'b1;
            if (rel[i])   ovc_clr[own_ov[i]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovc_busy <= '0;
        else        ovc_busy <= (ovc_busy & ~ovc_clr) | ovc_set;
    end

    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (ovc_clr != '0 && (ovc_clr & ovc_set) == '0) |=> ((ovc_busy & $past(ovc_clr)) == '0)); // R6
endmodule

// File: tb/test_escroute_sel.sv
module test_escroute_sel;
    localparam int NPORT = 5;
    localparam int NODES = 8;
    localparam int ID_W  = 3;
    localparam int PW    = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NPORT-1:0]       in_valid = '0;
    logic [2*NPORT-1:0]     in_kind = '0;
    logic [ID_W*NPORT-1:0]  in_dest = '0;
    logic [NPORT-1:0]       in_on_esc = '0;
    logic [NODES*NPORT-1:0] sp_table;
    logic [NODES*NPORT-1:0] ud_table;
    logic [NPORT-1:0]       out_fwd;
    logic [PW*NPORT-1:0]    out_port;
    logic [NPORT-1:0]       out_vc;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    // destination rows: row d is bits [d*5 +: 5], bit p = port p
    assign sp_table = {5'b00100, 5'b11000, 5'b00010, 5'b10100,
                       5'b01000, 5'b00110, 5'b00010, 5'b00001};
    assign ud_table = {5'b10000, 5'b00010, 5'b01000, 5'b00010,
                       5'b10000, 5'b01000, 5'b00100, 5'b00001};

    escroute_sel #(.NPORT(NPORT), .NODES(NODES)) i_escroute_sel (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_dest(in_dest), .in_on_esc(in_on_esc), .sp_table(sp_table),
        .ud_table(ud_table), .out_fwd(out_fwd), .out_port(out_port), .out_vc(out_vc)
    );

    // {input, dest, on_esc, exp_fwd, exp_port, exp_vc}, all single flits
    localparam logic [11:0] VEC [6] = '{
        {3'd1, 3'd2, 1'b0, 1'b1, 3'd1, 1'b0},   // R2
        {3'd2, 3'd4, 1'b1, 1'b1, 3'd1, 1'b1},   // R4
        {3'd4, 3'd6, 1'b0, 1'b1, 3'd3, 1'b0},   // R2
        {3'd3, 3'd3, 1'b1, 1'b1, 3'd4, 1'b1},   // R4
        {3'd2, 3'd0, 1'b0, 1'b1, 3'd0, 1'b0},   // R2
        {3'd0, 3'd1, 1'b1, 1'b1, 3'd1, 1'b0}    // R4 local ignores escape bit
    };

    task automatic clear_in();
        in_valid = '0; in_kind = '0; in_dest = '0; in_on_esc = '0;
    endtask

    task automatic drv(int i, logic [1:0] k, int d, logic e);
        in_valid[i] = 1'b1;
        in_kind[2*i +: 2] = k;
        in_dest[i*ID_W +: ID_W] = ID_W'(d);
        in_on_esc[i] = e;
    endtask

    task automatic chk(int i, logic ev, int ep, logic evc, string tag);
        logic ok;
        n_chk++;
        ok = (out_fwd[i] == ev);
        if (ev) ok = ok && (int'(out_port[i*PW +: PW]) == ep) && (out_vc[i] == evc);
        if (!ok) begin
            n_bad++;
            $display("FAIL %s in%0d: fwd=%0b port=%0d vc=%0b expected fwd=%0b port=%0d vc=%0b",
                     tag, i, out_fwd[i], out_port[i*PW +: PW], out_vc[i], ev, ep, evc);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        clear_in();
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(); #1;
        for (int i = 0; i < NPORT; i++) chk(i, 1'b0, 0, 1'b0, "R1");

        for (int n = 0; n < 6; n++) begin
            cyc();
            drv(int'(VEC[n][11:9]), 2'b11, int'(VEC[n][8:6]), VEC[n][5]);
            #1;
            chk(int'(VEC[n][11:9]), VEC[n][4], int'(VEC[n][3:1]), VEC[n][0], "R2/R4 vector");
        end

        // A: head takes shortest-path adaptive port
        cyc(); drv(1, 2'b00, 1, 1'b0); #1;
        chk(1, 1'b1, 1, 1'b0, "R2 head");
        // B: port1 VC0 busy -> second input falls back to escape; holder sends body
        cyc(); drv(1, 2'b01, 1, 1'b0); drv(2, 2'b00, 1, 1'b0); #1;
        chk(1, 1'b1, 1, 1'b0, "R6 body");
        chk(2, 1'b1, 2, 1'b1, "R3/R10 fallback");
        // C: tail of input1; escape-locked head stalls on busy port2 VC1
        cyc(); drv(1, 2'b10, 1, 1'b0); drv(3, 2'b00, 1, 1'b1); #1;
        chk(1, 1'b1, 1, 1'b0, "R6 tail");
        chk(3, 1'b0, 0, 1'b0, "R5 stall");
        // D: released VC is free again; input2 tail
        cyc(); drv(3, 2'b11, 1, 1'b0); drv(2, 2'b10, 1, 1'b0); #1;
        chk(3, 1'b1, 1, 1'b0, "R6 release");
        chk(2, 1'b1, 2, 1'b1, "R6 tail escape");
        // E: retried escape head now succeeds
        cyc(); drv(3, 2'b00, 1, 1'b1); #1;
        chk(3, 1'b1, 2, 1'b1, "R5 retry");
        // F: stray body on idle input ignored
        cyc(); drv(4, 2'b01, 1, 1'b0); drv(3, 2'b10, 1, 1'b1); #1;
        chk(4, 1'b0, 0, 1'b0, "R9 stray body");
        chk(3, 1'b1, 2, 1'b1, "R6 tail");
        // G: single flit in D left port1 VC0 free
        cyc(); drv(4, 2'b00, 1, 1'b0); #1;
        chk(4, 1'b1, 1, 1'b0, "R7 no hold");
        cyc(); drv(4, 2'b10, 1, 1'b0); #1;
        chk(4, 1'b1, 1, 1'b0, "R6 tail");
        // I/J: contention on port3 VC0, pointer at input0
        cyc(); drv(1, 2'b11, 6, 1'b0); drv(3, 2'b11, 6, 1'b0); #1;
        chk(1, 1'b1, 3, 1'b0, "R8 first grant");
        chk(3, 1'b0, 0, 1'b0, "R8 loser");
        cyc(); drv(1, 2'b11, 6, 1'b0); drv(3, 2'b11, 6, 1'b0); #1;
        chk(3, 1'b1, 3, 1'b0, "R8 rotated grant");
        chk(1, 1'b0, 0, 1'b0, "R8 loser");

        cyc();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule